// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit logical word address into a 20-bit physical word address on each CPU memory cycle. A 4-bit address-state input selects one of sixteen groups of page entries. Within a group, instruction fetches and data accesses each have their own set of sixteen entries. The upper four bits of the logical address index an entry, and the lower twelve bits pass through unchanged as the word offset. Each entry holds an 8-bit physical page, which selects one of 256 pages of 4K words, so the physical space is one megaword. Each entry also holds a 4-bit lock, an execute-protect bit and a write-protect bit.

The address, group, key and cycle type are taken while the address strobe is high. When the strobe falls, the entry is looked up. On the clock edge that closes that first low cycle, the block drives the physical address, an active-low protection error, and a ready flag. The ready flag drops for exactly one clock when the physical page differs from the page of the previous access. A plain synchronous write port loads the entries.

Top module: `pageMapUnit`

## Requirements
- R1: While `rstN` is low and after it rises, `readyOut` is 1, `protErrN` is 1 and `physAddr` is 0 until the first access is committed.
- R2: An access commits on the clock edge that closes the first cycle with `addrStrobe` low after a cycle with it high. From that edge `physAddr` equals {entry page, logAddr[11:0]}.
- R3: The entry is chosen by `addrState` (group), by `isData` (1 selects the data set, 0 the instruction set) and by logAddr[15:12] (index). The values used are those present in the last cycle with `addrStrobe` high.
- R4: If the access key differs from the entry lock, `protErrN` goes low at commit.
- R5: A key of 0 matches any lock, and a lock of 15 accepts any key. Neither case raises an error on its own.
- R6: An instruction access (`isData`=0) to an entry with execute-protect set drives `protErrN` low at commit.
- R7: A data write (`isData`=1, `isWrite`=1) to an entry with write-protect set drives `protErrN` low at commit. A data read of the same entry raises no error.
- R8: `protErrN` returns to 1 on the first edge at which `addrStrobe` is high. It is otherwise held between commits.
- R9: At a commit whose page differs from the previously committed page, `readyOut` is 0 for exactly one clock. At a commit to the same page it stays 1.
- R10: After reset no page is current, so the first committed access drops `readyOut`.
- R11: With `cfgWe` high, `cfgData` is written at the clock edge to the entry at cfgAddr = {group[8:5], set[4] (1 = data), index[3:0]}. The entry layout is page [13:6], lock [5:2], execute-protect [1], write-protect [0].
- R12: Changes on `logAddr`, `addrState`, `accessKey` or the cycle-type inputs while `addrStrobe` stays low do not change `physAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| addrStrobe | input | 1 | Address strobe, high while the address is valid |
| logAddr | input | 16 | Logical word address |
| addrState | input | 4 | Page group select |
| isData | input | 1 | 1 = data cycle, 0 = instruction cycle |
| isWrite | input | 1 | 1 = write cycle |
| accessKey | input | 4 | Access key matched against the entry lock |
| cfgWe | input | 1 | Entry write enable |
| cfgAddr | input | 9 | Entry select {group, set, index} |
| cfgData | input | 14 | Entry value {page, lock, exec-protect, write-protect} |
| physAddr | output | 20 | Translated physical word address |
| readyOut | output | 1 | 0 for one clock on a page change |
| protErrN | output | 1 | Active-low protection error |

## Verification
A wrong current-page record shows up as a dropped or missing `readyOut` pulse, on the commit edge of the very next access. A wrong latch or a wrong entry lookup shows up as a mismatched `physAddr` or `protErrN` at that same commit edge. An error flag that is not cleared stays visible one cycle into the next strobe. The reference model predicts all three outputs on every clock, so any deviation is reported within one cycle of the commit that exposes it.

// File: rtl/pageMapPkg.sv
package pageMapPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // take address, key and cycle type
    logic commit;   // register lookup result, update current page
  } pageMapCtl_t;
endpackage

// File: rtl/pageMapPath.sv
module pageMapPath
  import pageMapPkg::*;
#(
  parameter int LOG_W   = 16,
  parameter int IDX_W   = 4,
  parameter int GRP_W   = 4,
  parameter int PPAGE_W = 8,
  parameter int KEY_W   = 4,
  localparam int OFFS_W = LOG_W - IDX_W,
  localparam int PHYS_W = PPAGE_W + OFFS_W,
  localparam int ENT_W  = PPAGE_W + KEY_W + 2,
  localparam int CFGA_W = GRP_W + 1 + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pageMapCtl_t       ctl,
  input  logic [LOG_W-1:0]  logAddr,
  input  logic [GRP_W-1:0]  addrState,
  input  logic              isData,
  input  logic              isWrite,
  input  logic [KEY_W-1:0]  accessKey,
  input  logic              cfgWe,
  input  logic [CFGA_W-1:0] cfgAddr,
  input  logic [ENT_W-1:0]  cfgData,
  output logic [PHYS_W-1:0] physAddr,
  output logic              violation,
  output logic              miss
);
  localparam int DEPTH = 1 << CFGA_W;

  logic [ENT_W-1:0] pageTbl [DEPTH];

  always_ff @(posedge clk) begin
    if (cfgWe) pageTbl[cfgAddr] <= cfgData;
  end

  logic [LOG_W-1:0] latAddr;
  logic [GRP_W-1:0] latGrp;
  logic [KEY_W-1:0] latKey;
  logic             latData, latWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddr  <= '0;
      latGrp   <= '0;
      latKey   <= '0;
      latData  <= 1'b0;
      latWrite <= 1'b0;
    end else if (ctl.capture) begin
      latAddr  <= logAddr;
      latGrp   <= addrState;
      latKey   <= accessKey;
      latData  <= isData;
      latWrite <= isWrite;
    end
  end

  logic [CFGA_W-1:0]  selIdx;
  logic [ENT_W-1:0]   entry;
  logic [PPAGE_W-1:0] entPage;
  logic [KEY_W-1:0]   entLock;
  logic               entExec, entWprot, keyOk;

  assign selIdx   = {latGrp, latData, latAddr[LOG_W-1 -: IDX_W]};
  assign entry    = pageTbl[selIdx];
  assign entPage  = entry[ENT_W-1 -: PPAGE_W];
  assign entLock  = entry[KEY_W+1:2];
  assign entExec  = entry[1];
  assign entWprot = entry[0];

  assign keyOk     = (latKey == '0) || (entLock == '1) || (latKey == entLock);
  assign violation = !keyOk || (!latData && entExec) || (latData && latWrite && entWprot);

  logic [PPAGE_W-1:0] curPage;
  logic               curValid;

  assign miss = !curValid || (entPage != curPage);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physAddr <= '0;
      curPage  <= '0;
      curValid <= 1'b0;
    end else if (ctl.commit) begin
      physAddr <= {entPage, latAddr[OFFS_W-1:0]};
      curPage  <= entPage;
      curValid <= 1'b1;
    end
  end
endmodule

// File: rtl/pageMapCtrl.sv
module pageMapCtrl
  import pageMapPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStrobe,
  input  logic        violation,
  input  logic        miss,
  output pageMapCtl_t ctl,
  output logic        readyOut,
  output logic        protErrN
);
  logic strbQ;
  logic strbFall;

  assign strbFall    = strbQ && !addrStrobe;
  assign ctl.capture = addrStrobe;
  assign ctl.commit  = strbFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strbQ    <= 1'b0;
      readyOut <= 1'b1;
      protErrN <= 1'b1;
    end else begin
      strbQ    <= addrStrobe;
      readyOut <= !(strbFall && miss);
      if (addrStrobe)    protErrN <= 1'b1;
      else if (strbFall) protErrN <= !violation;
    end
  end
endmodule

// File: rtl/pageMapUnit.sv
module pageMapUnit
  import pageMapPkg::*;
#(
  parameter int LOG_W   = 16,
  parameter int IDX_W   = 4,
  parameter int GRP_W   = 4,
  parameter int PPAGE_W = 8,
  parameter int KEY_W   = 4,
  localparam int OFFS_W = LOG_W - IDX_W,
  localparam int PHYS_W = PPAGE_W + OFFS_W,
  localparam int ENT_W  = PPAGE_W + KEY_W + 2,
  localparam int CFGA_W = GRP_W + 1 + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic [LOG_W-1:0]  logAddr,
  input  logic [GRP_W-1:0]  addrState,
  input  logic              isData,
  input  logic              isWrite,
  input  logic [KEY_W-1:0]  accessKey,
  input  logic              cfgWe,
  input  logic [CFGA_W-1:0] cfgAddr,
  input  logic [ENT_W-1:0]  cfgData,
  output logic [PHYS_W-1:0] physAddr,
  output logic              readyOut,
  output logic              protErrN
);
  pageMapCtl_t ctl;
  logic        violation, miss;

  pageMapCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe),
    .violation(violation), .miss(miss),
    .ctl(ctl), .readyOut(readyOut), .protErrN(protErrN)
  );

  pageMapPath #(
    .LOG_W(LOG_W), .IDX_W(IDX_W), .GRP_W(GRP_W), .PPAGE_W(PPAGE_W), .KEY_W(KEY_W)
  ) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .logAddr(logAddr), .addrState(addrState), .isData(isData), .isWrite(isWrite),
    .accessKey(accessKey), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .physAddr(physAddr), .violation(violation), .miss(miss)
  );
endmodule

// File: rtl/pageMapChk.sv
module pageMapChk #(
  parameter int PHYS_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrStrobe,
  input logic              readyOut,
  input logic              protErrN,
  input logic [PHYS_W-1:0] physAddr
);
  assert_ready_one_clock_R9: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |=> readyOut);

  assert_ready_only_at_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(addrStrobe) |=> readyOut);

  assert_err_cleared_by_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobe |=> protErrN);

  assert_err_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStrobe && !$fell(addrStrobe)) |=> $stable(protErrN));

  assert_phys_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(addrStrobe) |=> $stable(physAddr));
endmodule

bind pageMapUnit pageMapChk #(.PHYS_W(PHYS_W)) chk_i (
  .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe),
  .readyOut(readyOut), .protErrN(protErrN), .physAddr(physAddr)
);

// File: tb/pageMapUnit_tb.sv
module pageMapUnit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrStrobe = 1'b0;
  logic [15:0] logAddr = '0;
  logic [3:0]  addrState = '0;
  logic        isData = 1'b0;
  logic        isWrite = 1'b0;
  logic [3:0]  accessKey = '0;
  logic        cfgWe = 1'b0;
  logic [8:0]  cfgAddr = '0;
  logic [13:0] cfgData = '0;
  logic [19:0] physAddr;
  logic        readyOut, protErrN;

  int checks = 0;
  int failures = 0;
  bit modelOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pageMapUnit dut_i (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .logAddr(logAddr),
    .addrState(addrState), .isData(isData), .isWrite(isWrite), .accessKey(accessKey),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .physAddr(physAddr), .readyOut(readyOut), .protErrN(protErrN)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [13:0] mkEnt(input logic [7:0] pg, input logic [3:0] lk,
                                        input logic ex, input logic wp);
    return {pg, lk, ex, wp};
  endfunction

  // behavioural reference model
  logic [13:0] mTbl [512];
  logic [15:0] mAddr; logic [3:0] mGrp, mKey; logic mData, mWr;
  logic        mPrevStrb, mCurValid;
  logic [7:0]  mCur;
  logic [19:0] mPhys;
  logic        mRdy, mErr;

  always @(posedge clk) begin
    if (!rstN) begin
      mPrevStrb = 0; mCurValid = 0; mCur = 0; mPhys = 0; mRdy = 1; mErr = 1;
    end else begin
      logic [13:0] e;
      logic viol;
      mRdy = 1;
      if (mPrevStrb && !addrStrobe) begin
        e = mTbl[{mGrp, mData, mAddr[15:12]}];
        mPhys = {e[13:6], mAddr[11:0]};
        viol = !(mKey == 0 || e[5:2] == 4'hF || mKey == e[5:2]);
        if (!mData && e[1]) viol = 1;
        if (mData && mWr && e[0]) viol = 1;
        mErr = !viol;
        if (!mCurValid || e[13:6] != mCur) mRdy = 0;
        mCur = e[13:6]; mCurValid = 1;
      end
      if (addrStrobe) begin
        mErr = 1;
        mAddr = logAddr; mGrp = addrState; mKey = accessKey; mData = isData; mWr = isWrite;
      end
      mPrevStrb = addrStrobe;
    end
    if (cfgWe) mTbl[cfgAddr] = cfgData;
  end

  always @(negedge clk) begin
    if (modelOn) begin
      chk("R2 physAddr per cycle", 32'(physAddr), 32'(mPhys));
      chk("R8 protErrN per cycle", 32'(protErrN), 32'(mErr));
      chk("R9 readyOut per cycle", 32'(readyOut), 32'(mRdy));
    end
  end

  task automatic wrEnt(input logic [8:0] a, input logic [13:0] d);
    @(negedge clk); cfgWe = 1; cfgAddr = a; cfgData = d;
    @(negedge clk); cfgWe = 0;
  endtask

  // strobe high one cycle, then low; returns at the negedge after the commit edge
  task automatic acc(input logic [3:0] g, input logic d, input logic w,
                     input logic [3:0] k, input logic [15:0] a);
    @(negedge clk);
    addrStrobe = 1; addrState = g; isData = d; isWrite = w; accessKey = k; logAddr = a;
    @(negedge clk); addrStrobe = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 readyOut in reset", 32'(readyOut), 1);
    chk("R1 protErrN in reset", 32'(protErrN), 1);
    chk("R1 physAddr in reset", 32'(physAddr), 0);
    rstN = 1;
    // R11: load every entry, then specific ones
    for (int i = 0; i < 512; i++) wrEnt(9'(i), mkEnt(8'(i) ^ 8'h5A, 4'hF, 1'b0, 1'b0));
    wrEnt({4'd3, 1'b1, 4'd2}, mkEnt(8'h47, 4'h9, 1'b0, 1'b0));
    wrEnt({4'd3, 1'b0, 4'd2}, mkEnt(8'h81, 4'h9, 1'b1, 1'b0));
    wrEnt({4'd5, 1'b1, 4'hA}, mkEnt(8'hC3, 4'hF, 1'b0, 1'b1));
    @(negedge clk);
    chk("R1 physAddr idle after reset", 32'(physAddr), 0);
    chk("R1 readyOut idle after reset", 32'(readyOut), 1);
    modelOn = 1;

    acc(4'd3, 1, 0, 4'h9, 16'h2ABC);
    chk("R2 R11 translated address", 32'(physAddr), 32'h47ABC);
    chk("R10 first access is a miss", 32'(readyOut), 0);
    chk("R4 matching key no error", 32'(protErrN), 1);
    @(negedge clk);
    chk("R9 ready back after one clock", 32'(readyOut), 1);

    acc(4'd3, 1, 0, 4'h9, 16'h2123);
    chk("R2 offset passes through", 32'(physAddr), 32'h47123);
    chk("R9 same page keeps ready", 32'(readyOut), 1);

    acc(4'd3, 1, 0, 4'h4, 16'h2000);
    chk("R4 key mismatch error", 32'(protErrN), 0);

    acc(4'd3, 1, 0, 4'h0, 16'h2000);
    chk("R5 key zero matches", 32'(protErrN), 1);

    acc(4'd3, 0, 0, 4'h9, 16'h2000);
    chk("R3 instruction set selected", 32'(physAddr), 32'h81000);
    chk("R6 execute protect error", 32'(protErrN), 0);
    chk("R9 page change drops ready", 32'(readyOut), 0);

    acc(4'd5, 1, 1, 4'h6, 16'hA555);
    chk("R3 group five data set", 32'(physAddr), 32'hC3555);
    chk("R7 write to protected page", 32'(protErrN), 0);

    @(negedge clk);
    addrStrobe = 1; addrState = 4'd5; isData = 1; isWrite = 0; accessKey = 4'h6; logAddr = 16'hA555;
    @(negedge clk);
    chk("R8 error cleared by strobe", 32'(protErrN), 1);
    addrStrobe = 0;
    @(negedge clk);
    chk("R7 read of write-protected page", 32'(protErrN), 1);
    chk("R5 lock fifteen accepts key", 32'(physAddr), 32'hC3555);

    logAddr = 16'h0FFF; addrState = 4'd0; isData = 0; accessKey = 4'h3;
    repeat (3) @(negedge clk);
    chk("R12 inputs ignored while strobe low", 32'(physAddr), 32'hC3555);

    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      int hi = 1 + ($urandom % 2);
      int lo = 1 + ($urandom % 3);
      @(negedge clk);
      addrStrobe = 1;
      addrState = ($urandom % 2) ? 4'd3 : 4'($urandom);
      isData = 1'($urandom); isWrite = 1'($urandom);
      accessKey = 4'($urandom); logAddr = 16'($urandom);
      cfgWe = ($urandom % 4 == 0); cfgAddr = 9'($urandom); cfgData = 14'($urandom);
      for (int h = 1; h < hi; h++) begin
        @(negedge clk); cfgWe = 0; logAddr = 16'($urandom);
      end
      for (int l = 0; l < lo; l++) begin
        @(negedge clk); addrStrobe = 0; cfgWe = 0; logAddr = 16'($urandom);
      end
    end
    repeat (3) @(negedge clk);
    modelOn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule